// File: doc/BRIEF.md
# Inter-Processor Interrupt and Mailbox Controller

This block lets any of several processor cores raise interrupts on any other core and hand startup parameters to a core through a small mailbox. Each core owns a register window on a shared memory-mapped bus. The window holds a 32-bit pending-interrupt status word and a 32-bit enable word. It also has two write-only ports, one that sets status bits and one that clears them, and a mailbox of 64-bit words. Each status bit stands for one independent interrupt type. A sender raises a type on a target core by writing ones to that core's set port. The receiving core acknowledges by writing the same ones to its own clear port. Writing to the status word itself does nothing.

Each core has one interrupt output. It is registered, and it is high while any pending status bit of that core is also enabled. The mailbox supports a boot handshake. The boot core writes the upper words first and word 0 last, and a nonzero word 0 tells the target that its entry address is valid. The started core then writes zero back to word 0. Any core may write any mailbox.

Windows are 0x100 bytes apart and indexed by the address bits above the window offset. Inside a window: status 0x00, enable 0x04, set port 0x08, clear port 0x0C, mailbox words at 0x20, 0x28, 0x30 and 0x38. Writes take effect on the cycle the strobe is sampled. Reads return data one cycle after the read strobe.

Top module: `ipi_mbox_ctrl`

## Requirements
- R1: After a synchronous reset, every status word, enable word and mailbox word reads zero, every interrupt output is low, and `bus_rvalid` is low.
- R2: A write to a core's set port (offset 0x08) turns on each status bit of that core whose write-data bit is 1. Status bits written as 0 keep their value.
- R3: A write to a core's clear port (offset 0x0C) turns off each status bit of that core whose write-data bit is 1. Status bits written as 0 keep their value.
- R4: The enable word (offset 0x04) stores write-data bits 31:0. Bits 63:32 of the write are dropped. Reads of the status and enable words return zero in bits 63:32.
- R5: A core's interrupt output is high exactly when the status AND enable of that core was nonzero one clock earlier. A write therefore shows at the interrupt output on the second rising edge after the write strobe is sampled.
- R6: Reads of the set port, the clear port and any unmapped offset return zero.
- R7: Each core has four 64-bit mailbox words at offsets 0x20, 0x28, 0x30 and 0x38. A write stores all 64 bits, and a read returns the last value written, including zero.
- R8: Address bits 9:8 select the core window. A write to one core's window changes no register of any other core.
- R9: `bus_rvalid` is high for exactly the cycle after each cycle in which `bus_rd` was sampled high, and `bus_rdata` is zero whenever `bus_rvalid` is low.
- R10: A write to the status offset (0x00) leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 10 | Byte address: bits 9:8 core, bits 7:0 offset in window |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| core_irq | output | 4 | Registered interrupt line per core |

## Verification
Corrupt status or enable state shows up in two places: the next read of that word over the bus, and the core's interrupt line, two rising edges after the write that caused it. The bench therefore samples the interrupt both one cycle early, when it must still hold the old value, and at the exact edge it must change. A mailbox entry holding a stale or wrong value, or one that leaks between cores, appears on the read that follows. The bench reads back the neighbour core's words after each handshake to catch this. A misaligned read pipeline shows as a response with no request behind it, or as nonzero data while `bus_rvalid` is low. The scoreboard flags both in the cycle they occur.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

  // width of the per-core window offset field
  localparam int WIN_W = 8;

  // window offsets; the boot handshake relies on word order in the mailbox
  localparam logic [WIN_W-1:0] OFS_STATUS = 8'h00;
  localparam logic [WIN_W-1:0] OFS_ENABLE = 8'h04;
  localparam logic [WIN_W-1:0] OFS_SET    = 8'h08;
  localparam logic [WIN_W-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [WIN_W-1:0] OFS_MBOX   = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_SET,
    SEL_CLEAR,
    SEL_MBOX
  } reg_sel_e;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int MBOX_WORDS = 4,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WORD_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1,
  localparam int ADDR_W = WIN_W + CORE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [CORE_W-1:0] core_idx,
  output logic [WORD_W-1:0] word_idx
);

  logic [WIN_W-1:0] ofs;
  logic [WIN_W-1:0] rel;
  logic             core_ok;
  logic             in_mbox;

  assign ofs      = addr[WIN_W-1:0];
  assign core_idx = addr[WIN_W +: CORE_W];
  assign rel      = ofs - OFS_MBOX;

  // a window index past the last core is unmapped
  generate
    if (NUM_CORES == (1 << CORE_W)) begin : g_full
      assign core_ok = 1'b1;
    end else begin : g_part
      assign core_ok = (32'(core_idx) < NUM_CORES);
    end
  endgenerate

  assign in_mbox  = (ofs >= OFS_MBOX) && (rel[2:0] == 3'b000) &&
                    (32'(rel[WIN_W-1:3]) < MBOX_WORDS);
  assign word_idx = rel[3 +: WORD_W];

  always_comb begin
    sel = SEL_NONE;
    if (core_ok) begin
      if (in_mbox)                 sel = SEL_MBOX;
      else if (ofs == OFS_STATUS)  sel = SEL_STATUS;
      else if (ofs == OFS_ENABLE)  sel = SEL_ENABLE;
      else if (ofs == OFS_SET)     sel = SEL_SET;
      else if (ofs == OFS_CLEAR)   sel = SEL_CLEAR;
    end
  end

endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs #(
  parameter int IPI_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic             en_we,
  input  logic [IPI_W-1:0] wdata,
  output logic [IPI_W-1:0] status,
  output logic [IPI_W-1:0] enable,
  output logic             irq
);

  logic [IPI_W-1:0] set_mask;
  logic [IPI_W-1:0] clr_mask;
  logic [IPI_W-1:0] status_d;

  assign set_mask = set_we ? wdata : '0;
  assign clr_mask = clr_we ? wdata : '0;
  // a bit both set and cleared stays set: no raised request is lost
  assign status_d = (status & ~clr_mask) | set_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      if (en_we) enable <= wdata;
      irq <= |(status & enable);
    end
  end

endmodule

// File: rtl/ipi_mbox_ram.sv
module ipi_mbox_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic [DEPTH-1:0]  written;
  logic              written_q;

  // plain array with registered read, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) mem_q <= mem[raddr];
  end

  // one flop per entry stands in for clearing the array at reset
  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      if (re) written_q <= written[raddr];
    end
  end

  assign rdata = written_q ? mem_q : '0;

endmodule

// File: rtl/ipi_mbox_ctrl.sv
module ipi_mbox_ctrl
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int IPI_W      = 32,
  parameter int DATA_W     = 64,
  parameter int MBOX_WORDS = 4,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WORD_W = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1,
  localparam int ADDR_W = WIN_W + CORE_W,
  localparam int RAM_D  = NUM_CORES * MBOX_WORDS,
  localparam int RAM_AW = (RAM_D > 1) ? $clog2(RAM_D) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [NUM_CORES-1:0] core_irq
);

  reg_sel_e          sel;
  logic [CORE_W-1:0] core_idx;
  logic [WORD_W-1:0] word_idx;
  logic [RAM_AW-1:0] ram_addr;

  logic [NUM_CORES*IPI_W-1:0] status_all;
  logic [NUM_CORES*IPI_W-1:0] enable_all;

  logic              rd_mbox_q;
  logic [IPI_W-1:0]  reg_rd_q;
  logic [DATA_W-1:0] ram_rdata;

  ipi_addr_decode #(
    .NUM_CORES  (NUM_CORES),
    .MBOX_WORDS (MBOX_WORDS)
  ) dec_i (
    .addr     (bus_addr),
    .sel      (sel),
    .core_idx (core_idx),
    .word_idx (word_idx)
  );

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic hit;
      assign hit = bus_wr && (32'(core_idx) == c);
      ipi_core_regs #(
        .IPI_W (IPI_W)
      ) regs_i (
        .clk    (clk),
        .rst    (rst),
        .set_we (hit && sel == SEL_SET),
        .clr_we (hit && sel == SEL_CLEAR),
        .en_we  (hit && sel == SEL_ENABLE),
        .wdata  (bus_wdata[IPI_W-1:0]),
        .status (status_all[c*IPI_W +: IPI_W]),
        .enable (enable_all[c*IPI_W +: IPI_W]),
        .irq    (core_irq[c])
      );
    end
  endgenerate

  assign ram_addr = RAM_AW'(32'(core_idx) * MBOX_WORDS + 32'(word_idx));

  ipi_mbox_ram #(
    .DEPTH  (RAM_D),
    .DATA_W (DATA_W)
  ) ram_i (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr && sel == SEL_MBOX),
    .waddr (ram_addr),
    .wdata (bus_wdata),
    .re    (bus_rd && sel == SEL_MBOX),
    .raddr (ram_addr),
    .rdata (ram_rdata)
  );

  // register-read stage, aligned with the RAM's registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      rd_mbox_q  <= 1'b0;
      reg_rd_q   <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      rd_mbox_q  <= bus_rd && sel == SEL_MBOX;
      reg_rd_q   <= '0;
      if (bus_rd) begin
        if (sel == SEL_STATUS) reg_rd_q <= status_all[core_idx*IPI_W +: IPI_W];
        else if (sel == SEL_ENABLE) reg_rd_q <= enable_all[core_idx*IPI_W +: IPI_W];
      end
    end
  end

  always_comb begin
    if (!bus_rvalid)    bus_rdata = '0;
    else if (rd_mbox_q) bus_rdata = ram_rdata;
    else                bus_rdata = DATA_W'(reg_rd_q);
  end

endmodule

// File: rtl/ipi_mbox_ctrl_chk.sv
module ipi_mbox_ctrl_chk
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IPI_W     = 32,
  parameter int DATA_W    = 64,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W = WIN_W + CORE_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic                       bus_rvalid,
  input logic [NUM_CORES-1:0]       core_irq,
  input logic [NUM_CORES*IPI_W-1:0] status_all,
  input logic [NUM_CORES*IPI_W-1:0] enable_all
);

  logic [WIN_W-1:0] ofs;
  assign ofs = bus_addr[WIN_W-1:0];

  a_r9_rvalid_after_rd: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  a_r9_no_stray_rvalid: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  a_r9_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> (bus_rdata == '0));

  a_r6_set_port_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ofs == OFS_SET) |=> (bus_rdata == '0));

  a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ofs == OFS_STATUS) |=> $stable(status_all));

  generate
    for (genvar k = 0; k < NUM_CORES; k++) begin : g_chk
      logic hit;
      assign hit = bus_wr && (32'(bus_addr[WIN_W +: CORE_W]) == k);

      a_r2_set_visible: assert property (@(posedge clk) disable iff (rst)
        (hit && ofs == OFS_SET) |=>
        ((status_all[k*IPI_W +: IPI_W] & $past(bus_wdata[IPI_W-1:0]))
          == $past(bus_wdata[IPI_W-1:0])));

      a_r3_clear_visible: assert property (@(posedge clk) disable iff (rst)
        (hit && ofs == OFS_CLEAR) |=>
        ((status_all[k*IPI_W +: IPI_W] & $past(bus_wdata[IPI_W-1:0])) == '0));

      a_r5_irq_needs_enabled_pending: assert property (@(posedge clk) disable iff (rst)
        ((status_all[k*IPI_W +: IPI_W] & enable_all[k*IPI_W +: IPI_W]) == '0)
        |=> !core_irq[k]);
    end
  endgenerate

endmodule

bind ipi_mbox_ctrl ipi_mbox_ctrl_chk #(
  .NUM_CORES (NUM_CORES),
  .IPI_W     (IPI_W),
  .DATA_W    (DATA_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .core_irq   (core_irq),
  .status_all (status_all),
  .enable_all (enable_all)
);

// File: tb/ipi_mbox_ctrl_tb_top.sv
module ipi_mbox_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  core_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  ipi_mbox_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .core_irq   (core_irq)
  );

  function automatic logic [9:0] adr(input int core, input logic [7:0] ofs);
    return {2'(core), ofs};
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int core, input logic [7:0] ofs, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = adr(core, ofs); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issues a read and pushes the expected response
  task automatic rd(input int core, input logic [7:0] ofs, input logic [63:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = adr(core, ofs);
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: pops and compares each response as it appears
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_rvalid) begin
        if (sb_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R9: actual=rvalid expected=no response");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(bus_rdata, e.exp, e.tag);
        end
      end else if (bus_rdata != '0) begin
        total++; bad++;
        $display("FAIL R9: actual=%h expected=%h while idle", bus_rdata, 64'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(64'(core_irq), 64'h0, "R1 irq after reset");
    check(64'(bus_rvalid), 64'h0, "R1 rvalid after reset");
    for (int c = 0; c < 4; c++) begin
      rd(c, 8'h00, 64'h0, "R1 status reset");
      rd(c, 8'h04, 64'h0, "R1 enable reset");
      rd(c, 8'h20, 64'h0, "R1 mailbox word0 reset");
      rd(c, 8'h38, 64'h0, "R1 mailbox word3 reset");
    end

    // R4 enable keeps low half only
    wr(1, 8'h04, 64'hDEAD_BEEF_0000_00FF);
    rd(1, 8'h04, 64'h0000_0000_0000_00FF, "R4 enable low half");

    // R2 / R5 set and interrupt latency
    wr(1, 8'h08, 64'hFFFF_0000_0000_0101);
    check(64'(core_irq), 64'h0, "R5 irq one cycle early");
    @(negedge clk);
    check(64'(core_irq), 64'h2, "R5 irq raised on core1");
    rd(1, 8'h00, 64'h101, "R2 status after set");
    rd(0, 8'h00, 64'h0, "R8 core0 untouched");
    rd(2, 8'h00, 64'h0, "R8 core2 untouched");
    wr(1, 8'h08, 64'h10);
    rd(1, 8'h00, 64'h111, "R2 zero bits keep value");

    // R3 clear
    wr(1, 8'h0C, 64'h1);
    rd(1, 8'h00, 64'h110, "R3 clear one bit");
    check(64'(core_irq), 64'h2, "R5 irq held by enabled bit4");
    wr(1, 8'h0C, 64'h10);
    check(64'(core_irq), 64'h2, "R5 irq drops one cycle late");
    @(negedge clk);
    check(64'(core_irq), 64'h0, "R5 irq low with only masked bit8");
    rd(1, 8'h00, 64'h100, "R3 bit8 kept");

    // R10 status not directly writable
    wr(1, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1, 8'h00, 64'h100, "R10 status write ignored");

    // R6 zero reads
    rd(1, 8'h08, 64'h0, "R6 set port reads zero");
    rd(1, 8'h0C, 64'h0, "R6 clear port reads zero");
    rd(1, 8'h10, 64'h0, "R6 unmapped 0x10");
    rd(1, 8'h40, 64'h0, "R6 unmapped 0x40");

    // R7 boot handshake on core2: high words first, word0 last
    wr(2, 8'h38, 64'h0);
    wr(2, 8'h30, 64'h9000_0000_0012_3400);
    wr(2, 8'h28, 64'h9800_0000_00FF_FFF0);
    wr(2, 8'h20, 64'hFFFF_FFFF_8000_1000);
    rd(2, 8'h20, 64'hFFFF_FFFF_8000_1000, "R7 word0 entry");
    rd(2, 8'h28, 64'h9800_0000_00FF_FFF0, "R7 word1");
    rd(2, 8'h30, 64'h9000_0000_0012_3400, "R7 word2");
    rd(2, 8'h38, 64'h0, "R7 word3");
    rd(3, 8'h20, 64'h0, "R8 core3 mailbox untouched");
    rd(1, 8'h28, 64'h0, "R8 core1 mailbox untouched");
    wr(2, 8'h20, 64'h0);
    rd(2, 8'h20, 64'h0, "R7 word0 cleared by target");
    rd(2, 8'h28, 64'h9800_0000_00FF_FFF0, "R7 word1 retained");

    // R5 enable turning on a pending bit
    wr(3, 8'h08, 64'h8000_0000);
    @(negedge clk);
    check(64'(core_irq), 64'h0, "R5 pending but disabled");
    wr(3, 8'h04, 64'h8000_0000);
    check(64'(core_irq), 64'h0, "R5 enable latency");
    @(negedge clk);
    check(64'(core_irq), 64'h8, "R5 irq after enable");

    // R9 idle bus
    @(negedge clk);
    check(64'(bus_rvalid), 64'h0, "R9 rvalid idle");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R9: actual=%0d expected=0 responses outstanding", sb_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule